// File: doc/BRIEF.md
# I2C Block-Access Register Slave

This block is an I2C target device that owns seven 8-bit configuration registers and presents their contents on a parallel bus. Only whole-block transfers are supported. A write is the device address, two header bytes whose values are thrown away, and then data bytes that fill the registers from index 0 upward. A read is the device address, then a byte-count byte, then the registers from index 0 upward. There is no sub-addressing, so a host that wants to change register 3 rewrites registers 0 to 3.

The block runs on a fast system clock and oversamples SCL and SDA through a two-flop synchroniser. It detects START, STOP and SCL edges from the synchronised lines. It pulls SDA low through an output-enable pin and never drives SCL. The byte-level state machine has eight states:

- S_IDLE: waits for START.
- S_ADDR: shifts in the address byte.
- S_ADDR_ACK: acknowledges the address.
- S_RX: receives a byte.
- S_RX_ACK: acknowledges a received byte.
- S_TX: shifts out a byte.
- S_TX_ACK: samples the host's acknowledge.
- S_IGNORE: stays off the bus.

Its transitions are as follows:

- START from any state goes to S_ADDR.
- STOP from any state goes to S_IDLE.
- In S_ADDR, the SCL fall after the eighth bit goes to S_ADDR_ACK on an address match and to S_IGNORE otherwise.
- In S_ADDR_ACK, the next fall goes to S_TX for a read or to S_RX for a write.
- In S_RX, the fall after eight bits goes to S_RX_ACK, and the next fall returns to S_RX.
- In S_TX, the fall after eight bits goes to S_TX_ACK.
- In S_TX_ACK, the next fall goes back to S_TX when the host acknowledged and to S_IGNORE when it did not.

Top module: `i2c_blkreg_slave`

## Requirements
- R1: After reset, register k (k = 0..6) holds byte k of the default vector: 0x0F, 0x3C, 0xA5, 0x00, 0xFF, 0x81, 0x42. `regs_o[8k+7:8k]` is register k, and `sda_oe` is 0.
- R2: The device answers the 7-bit address 0x69 with R/W in bit 0. It acknowledges 0xD2 as a write and 0xD3 as a read by holding `sda_oe` = 1 (SDA low) through the ninth SCL pulse.
- R3: On a write, the first two bytes after the address are ignored. Each later byte is stored into the next register, starting at register 0.
- R4: Every byte received on a matched write is acknowledged, including both header bytes.
- R5: A STOP after any complete byte ends the write. Registers written before it keep their new values, and all others keep their old values.
- R6: A read first sends the byte count 7 and then registers 0 to 6, each MSB first. The device releases SDA during the host's acknowledge bit. A host NACK ends transmission until the next START or STOP.
- R7: Data bytes written beyond register 6 are acknowledged and discarded. Bytes read beyond register 6 are 0xFF.
- R8: A non-matching address byte is not acknowledged. Until the next START, the device never drives SDA and changes no register.
- R9: A repeated START aborts the current transfer and restarts address reception.
- R10: `sda_oe` changes only while the synchronised SCL is low, apart from the release forced by a START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| regs_o | output | 56 | Register bank, register k at bits 8k+7:8k |

## Verification
A corrupted bit counter or state shows up within one byte. The acknowledge then lands on the wrong SCL pulse, which the bench sees as a missing ACK or a shifted read byte. A wrong write pointer or header count puts data into the wrong register, and the per-clock comparison against the behavioural register model flags this as soon as the bus goes idle after the transfer. A wrong read index shows on the very next byte read back. Driving SDA outside an acknowledge or read slot would corrupt the host's bits, and the bench catches this as a level change while SCL is high.

// File: rtl/i2c_blkreg_pkg.sv
package i2c_blkreg_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR,
        S_ADDR_ACK,
        S_RX,
        S_RX_ACK,
        S_TX,
        S_TX_ACK,
        S_IGNORE
    } bus_state_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic sda_s,
    output logic start_det,
    output logic stop_det
);
    // index 0 = SCL, index 1 = SDA
    logic [1:0]              line_in;
    logic [1:0][STAGES-1:0]  chain;
    logic [1:0]              now_v;
    logic [1:0]              prev_v;

    assign line_in = {sda_i, scl_i};

    for (genvar g = 0; g < 2; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (!rst_n) chain[g] <= '1;
            else        chain[g] <= {chain[g][STAGES-2:0], line_in[g]};
        end
        assign now_v[g] = chain[g][STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_v <= '1;
        else        prev_v <= now_v;
    end

    assign scl_s     = now_v[0];
    assign sda_s     = now_v[1];
    assign scl_rise  = now_v[0] & ~prev_v[0];
    assign scl_fall  = ~now_v[0] & prev_v[0];
    assign start_det = now_v[0] & prev_v[0] & prev_v[1] & ~now_v[1];
    assign stop_det  = now_v[0] & prev_v[0] & ~prev_v[1] & now_v[1];
endmodule

// File: rtl/i2c_blkreg_bank.sv
module i2c_blkreg_bank #(
    parameter int NREG = 7,
    parameter int DW   = 8,
    parameter int IDXW = 4,
    parameter logic [NREG*DW-1:0] INIT = '0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [IDXW-1:0]     widx,
    input  logic [DW-1:0]       wdata,
    input  logic [IDXW-1:0]     ridx,
    output logic [DW-1:0]       rdata,
    output logic [NREG*DW-1:0]  regs_flat
);
    for (genvar i = 0; i < NREG; i++) begin : g_reg
        localparam logic [IDXW-1:0] MY_IDX = IDXW'(i);
        logic [DW-1:0] r;
        always_ff @(posedge clk) begin
            if (!rst_n)                     r <= INIT[i*DW +: DW];
            else if (we && widx == MY_IDX)  r <= wdata;
        end
        assign regs_flat[i*DW +: DW] = r;
    end

    // out-of-range index reads as all ones
    always_comb begin
        rdata = '1;
        for (int k = 0; k < NREG; k++) begin
            if (ridx == IDXW'(k)) rdata = regs_flat[k*DW +: DW];
        end
    end
endmodule

// File: rtl/i2c_blkreg_slave.sv
module i2c_blkreg_slave import i2c_blkreg_pkg::*; #(
    parameter logic [6:0] DEV_ADDR    = 7'h69,
    parameter int         NREG        = 7,
    parameter int         SYNC_STAGES = 2,
    parameter logic [NREG*BYTE_W-1:0] REG_INIT = 56'h42_81_FF_00_A5_3C_0F
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    scl_i,
    input  logic                    sda_i,
    output logic                    sda_oe,
    output logic [NREG*BYTE_W-1:0]  regs_o
);
    localparam int CNTW = $clog2(NREG + 3);
    localparam int BCW  = $clog2(BYTE_W + 1);
    localparam int HDR  = 2;
    localparam logic [CNTW-1:0]   CNT_MAX    = '1;
    localparam logic [BCW-1:0]    BITS_FULL  = BCW'(BYTE_W);
    localparam logic [BYTE_W-1:0] COUNT_BYTE = BYTE_W'(NREG);

    logic scl_s, scl_rise, scl_fall, sda_s, start_det, stop_det;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .sda_s(sda_s), .start_det(start_det), .stop_det(stop_det)
    );

    bus_state_t          state, nstate;
    logic [BCW-1:0]      bitcnt;
    logic [BYTE_W-1:0]   shreg, tx_sh;
    logic                rw_q, nack_q;
    logic [CNTW-1:0]     wr_cnt, rd_idx;
    logic                byte_done, addr_hit, we;
    logic [CNTW-1:0]     widx, ridx;
    logic [BYTE_W-1:0]   bank_rdata, item;

    assign byte_done = scl_fall && (bitcnt == BITS_FULL);
    assign addr_hit  = (shreg[7:1] == DEV_ADDR);
    assign we        = (state == S_RX) && byte_done && !start_det && !stop_det
                       && (wr_cnt >= CNTW'(HDR));
    assign widx      = wr_cnt - CNTW'(HDR);
    assign ridx      = rd_idx - CNTW'(1);
    assign item      = (rd_idx == '0) ? COUNT_BYTE : bank_rdata;

    i2c_blkreg_bank #(.NREG(NREG), .DW(BYTE_W), .IDXW(CNTW), .INIT(REG_INIT)) u_bank (
        .clk(clk), .rst_n(rst_n), .we(we), .widx(widx), .wdata(shreg),
        .ridx(ridx), .rdata(bank_rdata), .regs_flat(regs_o)
    );

    // next-state logic
    always_comb begin
        nstate = state;
        if (start_det)     nstate = S_ADDR;
        else if (stop_det) nstate = S_IDLE;
        else begin
            unique case (state)
                S_IDLE:     nstate = S_IDLE;
                S_ADDR:     if (byte_done) nstate = addr_hit ? S_ADDR_ACK : S_IGNORE;
                S_ADDR_ACK: if (scl_fall)  nstate = rw_q ? S_TX : S_RX;
                S_RX:       if (byte_done) nstate = S_RX_ACK;
                S_RX_ACK:   if (scl_fall)  nstate = S_RX;
                S_TX:       if (byte_done) nstate = S_TX_ACK;
                S_TX_ACK:   if (scl_fall)  nstate = nack_q ? S_IGNORE : S_TX;
                S_IGNORE:   nstate = S_IGNORE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nstate;
    end

    // datapath and SDA output
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bitcnt <= '0;
            shreg  <= '0;
            tx_sh  <= '0;
            rw_q   <= 1'b0;
            nack_q <= 1'b0;
            wr_cnt <= '0;
            rd_idx <= '0;
            sda_oe <= 1'b0;
        end else if (start_det) begin
            bitcnt <= '0;
            shreg  <= '0;
            wr_cnt <= '0;
            rd_idx <= '0;
            sda_oe <= 1'b0;
        end else if (stop_det) begin
            bitcnt <= '0;
            sda_oe <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE, S_IGNORE: begin
                end
                S_ADDR: begin
                    if (scl_rise) begin
                        shreg  <= {shreg[BYTE_W-2:0], sda_s};
                        bitcnt <= bitcnt + BCW'(1);
                    end else if (byte_done && addr_hit) begin
                        sda_oe <= 1'b1;
                        rw_q   <= shreg[0];
                    end
                end
                S_ADDR_ACK: begin
                    if (scl_fall) begin
                        if (rw_q) begin
                            tx_sh  <= {item[BYTE_W-2:0], 1'b0};
                            sda_oe <= ~item[BYTE_W-1];
                            bitcnt <= BCW'(1);
                            rd_idx <= rd_idx + CNTW'(1);
                        end else begin
                            sda_oe <= 1'b0;
                            bitcnt <= '0;
                        end
                    end
                end
                S_RX: begin
                    if (scl_rise) begin
                        shreg  <= {shreg[BYTE_W-2:0], sda_s};
                        bitcnt <= bitcnt + BCW'(1);
                    end else if (byte_done) begin
                        sda_oe <= 1'b1;
                        if (wr_cnt != CNT_MAX) wr_cnt <= wr_cnt + CNTW'(1);
                    end
                end
                S_RX_ACK: begin
                    if (scl_fall) begin
                        sda_oe <= 1'b0;
                        bitcnt <= '0;
                    end
                end
                S_TX: begin
                    if (byte_done) begin
                        sda_oe <= 1'b0;
                    end else if (scl_fall) begin
                        sda_oe <= ~tx_sh[BYTE_W-1];
                        tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b0};
                        bitcnt <= bitcnt + BCW'(1);
                    end
                end
                S_TX_ACK: begin
                    if (scl_rise) begin
                        nack_q <= sda_s;
                    end else if (scl_fall) begin
                        if (nack_q) begin
                            sda_oe <= 1'b0;
                        end else begin
                            tx_sh  <= {item[BYTE_W-2:0], 1'b0};
                            sda_oe <= ~item[BYTE_W-1];
                            bitcnt <= BCW'(1);
                            if (rd_idx != CNT_MAX) rd_idx <= rd_idx + CNTW'(1);
                        end
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/i2c_blkreg_checker.sv
module i2c_blkreg_checker import i2c_blkreg_pkg::*; #(
    parameter int NREG = 7,
    parameter int DW   = 8
) (
    input logic               clk,
    input logic               rst_n,
    input bus_state_t         state,
    input logic               sda_oe,
    input logic               scl_s,
    input logic               start_det,
    input logic               stop_det,
    input logic               we,
    input logic [NREG*DW-1:0] regs
);
    // R8: off the bus while idle or after a foreign address
    a_r8_quiet_when_not_selected: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE || state == S_IGNORE) |-> !sda_oe);

    // R10: SDA moves only while SCL is low, except START/STOP release
    a_r10_sda_moves_on_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> (!$past(scl_s) || $past(start_det) || $past(stop_det)));

    // R4: acknowledge slot holds SDA low
    a_r4_ack_slot_driven: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ADDR_ACK || state == S_RX_ACK) |-> sda_oe);

    // R6: released while the host acknowledges
    a_r6_release_for_host_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_TX_ACK) |-> !sda_oe);

    // R3: registers change only on a store strobe
    a_r3_store_only_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (regs != $past(regs)) |-> $past(we));
endmodule

bind i2c_blkreg_slave i2c_blkreg_checker #(.NREG(NREG), .DW(BYTE_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .state(state), .sda_oe(sda_oe), .scl_s(scl_s),
    .start_det(start_det), .stop_det(stop_det), .we(we), .regs(regs_o)
);

// File: tb/i2c_blkreg_slave_tb_top.sv
module i2c_blkreg_slave_tb_top;
    localparam int H = 16;
    localparam int Q = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        sda_oe;
    logic [55:0] regs_o;
    logic        sda_line;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    bit cmp_en = 1'b0;
    int mdl_viol = 0;
    int r10_viol = 0;
    logic prev_oe = 1'b0;
    int mdl [7];
    int wq [$];

    always #10 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    i2c_blkreg_slave dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe(sda_oe), .regs_o(regs_o)
    );

    function automatic logic [55:0] model_flat();
        logic [55:0] v;
        for (int k = 0; k < 7; k++) v[k*8 +: 8] = mdl[k][7:0];
        return v;
    endfunction

    // per-clock comparison against the behavioural model while the bus is idle
    always @(negedge clk) begin
        if (cmp_en && regs_o !== model_flat()) mdl_viol++;
        if (rst_n && sda_oe !== prev_oe && scl_m) r10_viol++;
        prev_oe <= sda_oe;
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic w(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; scl_m = 1'b1; w(H);
        sda_m = 1'b0; w(H);
        scl_m = 1'b0; w(Q);
    endtask

    task automatic i2c_rstart();
        sda_m = 1'b1; w(Q);
        scl_m = 1'b1; w(H);
        sda_m = 1'b0; w(H);
        scl_m = 1'b0; w(Q);
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; w(Q);
        scl_m = 1'b1; w(H);
        sda_m = 1'b1; w(H);
    endtask

    task automatic write_byte(input logic [7:0] b, output int acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; w(H);
            scl_m = 1'b1; w(H);
            scl_m = 1'b0; w(Q);
        end
        sda_m = 1'b1; w(H);
        scl_m = 1'b1; w(Q);
        acked = sda_line ? 0 : 1;
        w(Q);
        scl_m = 1'b0; w(Q);
    endtask

    task automatic read_byte(output int b, input bit mack);
        logic [7:0] v;
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            w(H);
            scl_m = 1'b1; w(Q);
            v[i] = sda_line;
            w(Q);
            scl_m = 1'b0;
        end
        w(Q);
        sda_m = !mack; w(H);
        scl_m = 1'b1; w(H);
        scl_m = 1'b0; w(Q);
        sda_m = 1'b1;
        b = int'(v);
    endtask

    task automatic settle_and_check(input string req);
        w(10);
        chk(req, "register bank", (regs_o == model_flat()) ? 1 : 0, 1);
        cmp_en = 1'b1;
        w(20);
        cmp_en = 1'b0;
    endtask

    // block write of wq contents; R2/R3/R4/R7 acks and model update
    task automatic do_write(input string req);
        int a;
        i2c_start();
        write_byte(8'hD2, a); chk("R2", "write address ack", a, 1);
        write_byte(8'h5A, a); chk("R4", "header byte 1 ack", a, 1);
        write_byte(8'hC3, a); chk("R4", "header byte 2 ack", a, 1);
        foreach (wq[k]) begin
            write_byte(wq[k][7:0], a);
            chk(k < 7 ? "R4" : "R7", "data byte ack", a, 1);
            if (k < 7) mdl[k] = wq[k] & 8'hFF;
        end
        i2c_stop();
        settle_and_check(req);
    endtask

    task automatic do_read(input int nitems);
        int a, b;
        i2c_start();
        write_byte(8'hD3, a); chk("R2", "read address ack", a, 1);
        read_byte(b, 1'b1); chk("R6", "byte count", b, 7);
        for (int k = 0; k < nitems; k++) begin
            read_byte(b, k != nitems - 1);
            chk(k < 7 ? "R6" : "R7", "read data", b, k < 7 ? mdl[k] : 8'hFF);
        end
        i2c_stop();
        w(10);
    endtask

    initial begin
        int a, b;
        mdl = '{8'h0F, 8'h3C, 8'hA5, 8'h00, 8'hFF, 8'h81, 8'h42};
        w(5);
        rst_n = 1'b1;
        w(5);
        // R1: defaults after reset
        chk("R1", "default bank", (regs_o == 56'h42_81_FF_00_A5_3C_0F) ? 1 : 0, 1);
        chk("R1", "sda_oe at reset", int'(sda_oe), 0);
        settle_and_check("R1");

        // R3: full block write
        wq = {};
        for (int k = 0; k < 7; k++) wq.push_back((8'h21 * (k + 1)) & 8'hFF);
        do_write("R3");
        do_read(7);

        // R5: partial write, stop after two data bytes
        wq = {8'hE7, 8'h18};
        do_write("R5");
        do_read(7);

        // R5: stop right after the header only
        wq = {};
        do_write("R5");

        // R7: overflow write and read past the end
        wq = {};
        for (int k = 0; k < 9; k++) wq.push_back(8'h90 + k);
        do_write("R7");
        do_read(9);

        // R8: foreign addresses are not acknowledged and change nothing
        i2c_start();
        write_byte(8'hA4, a); chk("R8", "foreign address nack", a, 0);
        write_byte(8'h00, a); chk("R8", "byte after foreign address", a, 0);
        write_byte(8'h00, a); chk("R8", "byte after foreign address", a, 0);
        write_byte(8'h77, a); chk("R8", "byte after foreign address", a, 0);
        i2c_stop();
        settle_and_check("R8");
        i2c_start();
        write_byte(8'hD0, a); chk("R8", "neighbour address nack", a, 0);
        i2c_stop();
        settle_and_check("R8");

        // R9: repeated START switches from write to read
        i2c_start();
        write_byte(8'hD2, a); chk("R9", "address ack", a, 1);
        write_byte(8'h01, a);
        write_byte(8'h02, a);
        write_byte(8'h11, a); chk("R9", "data ack", a, 1);
        mdl[0] = 8'h11;
        i2c_rstart();
        write_byte(8'hD3, a); chk("R9", "read address after Sr", a, 1);
        read_byte(b, 1'b1); chk("R9", "count after Sr", b, 7);
        read_byte(b, 1'b0); chk("R9", "reg0 after Sr", b, 8'h11);
        i2c_stop();
        settle_and_check("R9");

        chk("R3", "per-clock model mismatches", mdl_viol, 0);
        chk("R10", "sda_oe changes while SCL high", r10_viol, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule